// File: doc/BRIEF.md
# CPU Address Window Decoder

This block holds a bank of programmable address-decode windows that steer CPU physical addresses to devices. Each window names a device by a 4-bit target ID and an 8-bit attribute byte. Software programs each window through a 32-bit register port with a valid/write strobe. The block then compares every 36-bit CPU address against all enabled windows at once. It reports a hit or a miss, the target and attribute of the selected window, and the address to pass on to the device.

Window sizes are powers of two in 64 KiB steps. The size field is a mask of the address bits that form the offset inside the window. The lower-numbered windows also have a remap base. A hit in one of them turns the CPU address into a device-side address. The higher-numbered windows pass the address through unchanged.

The register map has two regions. The remappable windows take four words each. After them comes a 16-byte hole. The remaining windows follow, two words each.

Top module: `cpu_win_decoder`

## Requirements
- R1: After reset every window is disabled: every CPU address misses, and every register reads as zero.
- R2: Window control word: bit 0 is enable, bits 7:4 are target, bits 15:8 are attribute, bits 31:16 are (size in 64 KiB units) minus one. Bits 3:1 read back as zero.
- R3: Window base word: bits 31:16 are address bits 31:16 and bits 3:0 are address bits 35:32. All other bits read as zero. The low 16 address bits of a base are always zero.
- R4: An address hits a window when it equals the base on every bit above the offset mask. The offset mask has bits 15:0 set plus bit 16+k for each set bit k of the size field. A size field of N gives a window of (N+1)×64 KiB.
- R5: A window whose enable bit is clear never hits, whatever its other fields hold. Writing zero to its control word disables it.
- R6: When several enabled windows hit, the lowest-indexed one supplies target, attribute and address.
- R7: Windows below NUM_REMAP have a remap-low word (bits 31:16 kept) and a remap-high word (bits 3:0 kept, as address bits 35:32). On a hit in such a window the output address is the remap base ORed with (address AND offset mask).
- R8: A hit in a window at index NUM_REMAP or above outputs the CPU address unchanged.
- R9: On a miss, lkMiss is 1 and lkHit is 0, target and attribute are zero, and the output address equals the CPU address. lkHit and lkMiss are always complements.
- R10: Register offsets: window w < NUM_REMAP sits at w×0x10, with control, base, remap-low and remap-high at +0, +4, +8 and +0xC. Window w ≥ NUM_REMAP sits at NUM_REMAP×0x10 + 0x10 + (w−NUM_REMAP)×8, with control at +0 and base at +4.
- R11: The 16-byte hole after the remappable region and all offsets past the last window read as zero. Writes there change no register.
- R12: A read is accepted in the cycle regValid=1 and regWrite=0. regRdata holds the word and regRdValid is 1 during the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | REG_AW | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after the request |
| regRdValid | output | 1 | Read data valid |
| cpuAddr | input | ADDR_W | CPU physical address to decode |
| lkHit | output | 1 | Some enabled window matched |
| lkMiss | output | 1 | No window matched |
| lkTarget | output | 4 | Target ID of the selected window |
| lkAttr | output | 8 | Attribute of the selected window |
| lkAddrOut | output | ADDR_W | Translated or passed-through address |

## Verification
The bench probes the window edges one address inside and one outside, including a change only in bits 35:32. A design that takes the size field as the size itself, or drops the high base bits, would hit one of those outside addresses. Overlapping windows are programmed first in one remappable window and then in another, and the lower one is then disabled. A wrong priority order, or an enable bit that is not honoured, would select the wrong target or translation. The hole is written and read back, and so is the first window on each side of it, which catches stride or offset errors that would alias the hole onto a window. The last window is placed by offset and then proven by a lookup.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  localparam int WIN_IDX_W = 8;
  localparam int TGT_W = 4;
  localparam int ATTR_W = 8;
  localparam int SIZE_W = 16;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_RLO  = 2'd2,
    SEL_RHI  = 2'd3
  } regSel_e;

  // strobes handed from the register control to the datapath
  typedef struct packed {
    logic                 wrStb;
    logic                 rdStb;
    logic                 mapped;
    logic [WIN_IDX_W-1:0] win;
    regSel_e              sel;
  } regStb_t;
endpackage

// File: rtl/cwd_regctl.sv
module cwd_regctl
  import cwd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  output regStb_t           stb,
  output logic              regRdValid
);
  localparam logic [31:0] REGION1_END = 32'(NUM_REMAP * 16);
  localparam logic [31:0] GAP_END     = REGION1_END + 32'd16;
  localparam logic [31:0] REGION2_END = GAP_END + 32'((NUM_WIN - NUM_REMAP) * 8);

  logic [31:0] off;
  logic [31:0] rel2;

  assign off  = 32'(regAddr);
  assign rel2 = off - GAP_END;

  always_comb begin
    stb        = '0;
    stb.wrStb  = regValid & regWrite;
    stb.rdStb  = regValid & ~regWrite;
    stb.sel    = SEL_CTRL;
    if (off < REGION1_END) begin
      stb.mapped = 1'b1;
      stb.win    = WIN_IDX_W'(off >> 4);
      stb.sel    = regSel_e'(off[3:2]);
    end else if (off >= GAP_END && off < REGION2_END) begin
      stb.mapped = 1'b1;
      stb.win    = WIN_IDX_W'(32'(NUM_REMAP) + (rel2 >> 3));
      stb.sel    = off[2] ? SEL_BASE : SEL_CTRL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdValid <= 1'b0;
    else       regRdValid <= stb.rdStb;
  end
endmodule

// File: rtl/cwd_datapath.sv
module cwd_datapath
  import cwd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int ADDR_W    = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [TGT_W-1:0]  lkTarget,
  output logic [ATTR_W-1:0] lkAttr,
  output logic [ADDR_W-1:0] lkAddrOut
);
  localparam int HI_W  = ADDR_W - 32;
  localparam int TOP_W = ADDR_W - 16;

  logic [NUM_WIN-1:0]             winEn;
  logic [NUM_WIN-1:0][TGT_W-1:0]  winTgt;
  logic [NUM_WIN-1:0][ATTR_W-1:0] winAttr;
  logic [NUM_WIN-1:0][SIZE_W-1:0] winSize;
  logic [NUM_WIN-1:0][15:0]       baseLo;
  logic [NUM_WIN-1:0][HI_W-1:0]   baseHi;
  logic [NUM_REMAP-1:0][15:0]     rmpLo;
  logic [NUM_REMAP-1:0][HI_W-1:0] rmpHi;
  logic [NUM_WIN-1:0][ADDR_W-1:0] rmpBase;
  logic [NUM_WIN-1:0]             rmpOk;
  logic [NUM_WIN-1:0]             winHit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic selMe;
    assign selMe = stb.wrStb && stb.mapped && (stb.win == WIN_IDX_W'(w));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winEn[w]   <= 1'b0;
        winTgt[w]  <= '0;
        winAttr[w] <= '0;
        winSize[w] <= '0;
        baseLo[w]  <= '0;
        baseHi[w]  <= '0;
      end else if (selMe) begin
        case (stb.sel)
          SEL_CTRL: begin
            winEn[w]   <= regWdata[0];
            winTgt[w]  <= regWdata[7:4];
            winAttr[w] <= regWdata[15:8];
            winSize[w] <= regWdata[31:16];
          end
          SEL_BASE: begin
            baseLo[w] <= regWdata[31:16];
            baseHi[w] <= regWdata[HI_W-1:0];
          end
          default: ;
        endcase
      end
    end

    // compare address bits above the offset mask against the base
    assign winHit[w] = winEn[w] &&
      ((cpuAddr[ADDR_W-1:16] & ~{{HI_W{1'b0}}, winSize[w]}) == {baseHi[w], baseLo[w]});

    if (w < NUM_REMAP) begin : g_rmp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rmpLo[w] <= '0;
          rmpHi[w] <= '0;
        end else if (selMe && stb.sel == SEL_RLO) begin
          rmpLo[w] <= regWdata[31:16];
        end else if (selMe && stb.sel == SEL_RHI) begin
          rmpHi[w] <= regWdata[HI_W-1:0];
        end
      end
      assign rmpBase[w] = {rmpHi[w], rmpLo[w], 16'h0000};
      assign rmpOk[w]   = 1'b1;
    end else begin : g_pass
      assign rmpBase[w] = '0;
      assign rmpOk[w]   = 1'b0;
    end
  end

  // register read mux
  logic [31:0] rdNext;
  always_comb begin
    rdNext = '0;
    if (stb.mapped) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (stb.win == WIN_IDX_W'(w)) begin
          case (stb.sel)
            SEL_CTRL: rdNext = {winSize[w], winAttr[w], winTgt[w], 3'b000, winEn[w]};
            SEL_BASE: rdNext = {baseLo[w], 16'(baseHi[w])};
            SEL_RLO:  rdNext = rmpOk[w] ? {rmpBase[w][31:16], 16'h0000} : 32'h0;
            SEL_RHI:  rdNext = rmpOk[w] ? 32'(rmpBase[w][ADDR_W-1:32]) : 32'h0;
            default:  rdNext = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          regRdata <= '0;
    else if (stb.rdStb) regRdata <= rdNext;
  end

  // lookup: lowest index wins, so scan from the top down
  logic [TGT_W-1:0]  selTgt;
  logic [ATTR_W-1:0] selAttr;
  logic [ADDR_W-1:0] selMask;
  logic [ADDR_W-1:0] selRmp;
  logic              selRmpOk;
  logic [TOP_W-1:0]  unusedTop;

  always_comb begin
    selTgt   = '0;
    selAttr  = '0;
    selMask  = '0;
    selRmp   = '0;
    selRmpOk = 1'b0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (winHit[w]) begin
        selTgt   = winTgt[w];
        selAttr  = winAttr[w];
        selMask  = {{HI_W{1'b0}}, winSize[w], 16'hFFFF};
        selRmp   = rmpBase[w];
        selRmpOk = rmpOk[w];
      end
    end
  end

  assign unusedTop = '0;
  assign lkHit     = |winHit;
  assign lkMiss    = ~(|winHit);
  assign lkTarget  = selTgt;
  assign lkAttr    = selAttr;
  assign lkAddrOut = selRmpOk ? (selRmp | (cpuAddr & selMask)) : cpuAddr;
endmodule

// File: rtl/cpu_win_decoder.sv
module cpu_win_decoder
  import cwd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8,
  parameter int ADDR_W    = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regRdValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [3:0]        lkTarget,
  output logic [7:0]        lkAttr,
  output logic [ADDR_W-1:0] lkAddrOut
);
  regStb_t stb;

  cwd_regctl #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .stb(stb), .regRdValid(regRdValid)
  );

  cwd_datapath #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata),
    .regRdata(regRdata), .cpuAddr(cpuAddr), .lkHit(lkHit), .lkMiss(lkMiss),
    .lkTarget(lkTarget), .lkAttr(lkAttr), .lkAddrOut(lkAddrOut)
  );
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8,
  parameter int ADDR_W    = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              regValid,
  input logic              regWrite,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regRdata,
  input logic              regRdValid,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              lkHit,
  input logic              lkMiss,
  input logic [3:0]        lkTarget,
  input logic [7:0]        lkAttr,
  input logic [ADDR_W-1:0] lkAddrOut
);
  localparam int GAP_LO = NUM_REMAP * 16;

  logic gapRead;
  assign gapRead = regValid && !regWrite &&
                   (32'(regAddr) >= 32'(GAP_LO)) && (32'(regAddr) < 32'(GAP_LO + 16));

  a_r9_hit_miss_complement: assert property (@(posedge clk) disable iff (!rstN)
    lkHit != lkMiss);

  a_r9_miss_outputs: assert property (@(posedge clk) disable iff (!rstN)
    lkMiss |-> (lkTarget == 4'h0 && lkAttr == 8'h00 && lkAddrOut == cpuAddr));

  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkAddrOut[15:0] == cpuAddr[15:0]));

  a_r12_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite) |=> regRdValid);

  a_r12_no_stray_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && !regWrite) |=> !regRdValid);

  a_r11_gap_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    gapRead |=> (regRdata == 32'h0));
endmodule

bind cpu_win_decoder cwd_checker #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
  .regAddr(regAddr), .regRdata(regRdata), .regRdValid(regRdValid),
  .cpuAddr(cpuAddr), .lkHit(lkHit), .lkMiss(lkMiss), .lkTarget(lkTarget),
  .lkAttr(lkAttr), .lkAddrOut(lkAddrOut)
);

// File: tb/cpu_win_decoder_tb.sv
module cpu_win_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRdValid;
  logic [35:0] cpuAddr = '0;
  logic        lkHit, lkMiss;
  logic [3:0]  lkTarget;
  logic [7:0]  lkAttr;
  logic [35:0] lkAddrOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpu_win_decoder u_dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRdValid(regRdValid), .cpuAddr(cpuAddr), .lkHit(lkHit), .lkMiss(lkMiss),
    .lkTarget(lkTarget), .lkAttr(lkAttr), .lkAddrOut(lkAddrOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    chk({req, " R12 rdValid"}, 64'(regRdValid), 64'd1);
    chk(req, 64'(regRdata), 64'(exp));
  endtask

  task automatic look(input string req, input logic [35:0] a, input logic expHit,
                      input logic [3:0] expTgt, input logic [7:0] expAttr,
                      input logic [35:0] expOut);
    @(negedge clk);
    cpuAddr = a;
    #2;
    chk({req, " hit"}, 64'(lkHit), 64'(expHit));
    chk({req, " R9 miss"}, 64'(lkMiss), 64'(!expHit));
    chk({req, " target"}, 64'(lkTarget), 64'(expTgt));
    chk({req, " attr"}, 64'(lkAttr), 64'(expAttr));
    chk({req, " addr"}, 64'(lkAddrOut), 64'(expOut));
  endtask

  task automatic t_reset;
    rdChk("R1 ctrl0", 8'h00, 32'h0);
    rdChk("R1 rhi7", 8'h7C, 32'h0);
    rdChk("R1 ctrl19", 8'hE8, 32'h0);
    look("R1 lookup", 36'h0_0000_0000, 1'b0, 4'h0, 8'h00, 36'h0_0000_0000);
    look("R1 lookup hi", 36'hF_FFFF_FFFF, 1'b0, 4'h0, 8'h00, 36'hF_FFFF_FFFF);
  endtask

  task automatic t_gap;
    for (int i = 0; i < 4; i++) wr(8'h80 + 8'(i * 4), 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) rdChk("R11 hole", 8'h80 + 8'(i * 4), 32'h0);
    rdChk("R11 win7 rhi untouched", 8'h7C, 32'h0);
    rdChk("R11 win7 ctrl untouched", 8'h70, 32'h0);
    rdChk("R11 win8 ctrl untouched", 8'h90, 32'h0);
    wr(8'hF0, 32'hFFFF_FFFF);
    rdChk("R11 past end", 8'hF0, 32'h0);
    rdChk("R11 win19 base untouched", 8'hEC, 32'h0);
    look("R11 no window", 36'h0_0000_0000, 1'b0, 4'h0, 8'h00, 36'h0_0000_0000);
  endtask

  task automatic t_fields;
    wr(8'h30, 32'hFFFF_FFFF);
    rdChk("R2 ctrl mask", 8'h30, 32'hFFFF_FFF1);
    wr(8'h30, 32'h0);
    rdChk("R2 ctrl cleared", 8'h30, 32'h0);
    wr(8'h9C, 32'hFFFF_FFFF);
    rdChk("R3 base mask", 8'h9C, 32'hFFFF_000F);
    wr(8'h9C, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    rdChk("R7 remap lo mask", 8'h28, 32'hFFFF_0000);
    wr(8'h2C, 32'hFFFF_FFFF);
    rdChk("R7 remap hi mask", 8'h2C, 32'h0000_000F);
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h0);
  endtask

  task automatic t_passthrough;
    // window 9: 128 KiB at 0x3_0002_0000, target 7, attr 5A
    wr(8'h9C, 32'h0002_0003);
    wr(8'h98, 32'h0001_5A71);
    look("R8 R4 first", 36'h3_0002_0000, 1'b1, 4'h7, 8'h5A, 36'h3_0002_0000);
    look("R4 last", 36'h3_0003_FFFF, 1'b1, 4'h7, 8'h5A, 36'h3_0003_FFFF);
    look("R4 above", 36'h3_0004_0000, 1'b0, 4'h0, 8'h00, 36'h3_0004_0000);
    look("R4 below", 36'h3_0001_FFFF, 1'b0, 4'h0, 8'h00, 36'h3_0001_FFFF);
    look("R3 high bits", 36'h2_0002_0000, 1'b0, 4'h0, 8'h00, 36'h2_0002_0000);
    // disabled but fully populated
    wr(8'h98, 32'h0001_5A70);
    look("R5 enable clear", 36'h3_0002_1000, 1'b0, 4'h0, 8'h00, 36'h3_0002_1000);
    wr(8'h98, 32'h0);
    wr(8'h9C, 32'h0);
  endtask

  task automatic t_remap_priority;
    // window 1: 1 MiB at 0x8000_0000 -> 0x1_C000_0000, target 4 attr E0
    wr(8'h14, 32'h8000_0000);
    wr(8'h18, 32'hC000_0000);
    wr(8'h1C, 32'h0000_0001);
    wr(8'h10, 32'h000F_E041);
    look("R7 remap", 36'h0_8001_2345, 1'b1, 4'h4, 8'hE0, 36'h1_C001_2345);
    look("R7 window end", 36'h0_8010_0000, 1'b0, 4'h0, 8'h00, 36'h0_8010_0000);
    // window 0: 64 KiB at 0x8000_0000, remap base zero, target 2 attr 11
    wr(8'h04, 32'h8000_0000);
    wr(8'h00, 32'h0000_1121);
    look("R6 low index wins", 36'h0_8000_1234, 1'b1, 4'h2, 8'h11, 36'h0_0000_1234);
    look("R6 outside win0", 36'h0_8001_0000, 1'b1, 4'h4, 8'hE0, 36'h1_C001_0000);
    wr(8'h00, 32'h0);
    look("R5 zero disables", 36'h0_8000_1234, 1'b1, 4'h4, 8'hE0, 36'h1_C000_1234);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_last_window;
    wr(8'hEC, 32'h0000_0009);
    wr(8'hE8, 32'h0000_AB31);
    rdChk("R10 win19 ctrl", 8'hE8, 32'h0000_AB31);
    look("R10 win19 lookup", 36'h9_0000_0042, 1'b1, 4'h3, 8'hAB, 36'h9_0000_0042);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_gap();
    t_fields();
    t_passthrough();
    t_remap_priority();
    t_last_window();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule